// File: doc/BRIEF.md
# ADC control and flag-clearing logic

This block holds the digital control and status logic that sits beside an analog-to-digital converter. Software reaches it through a small register bus. The bus has an address, separate read and write strobes, and eight-bit data. Through the bus, software can:

- power the converter up or down,
- choose how conversion-complete flags are cleared,
- ask for a power-down during wait mode,
- set up an external trigger,
- enable a sequence-complete interrupt.

The block keeps one conversion-complete flag per channel, a result register per channel, a sequence-complete flag and a per-channel tag that marks untrustworthy results.

The sequencer and the analog converter are not part of this block; stimulus ports stand in for them. The sequencer reports a finished conversion with a channel number and data. It reports the end of a sequence on a separate strobe, and tells the block when it is idle. The trigger input is synchronised and shaped into a start-of-conversion request. That request is held back while the converter is off or still recovering from power-up. Flag clearing depends on the order of bus accesses. In the normal mode a flags-register read must come first and then the result read. In the fast mode any access to a result register clears that channel's flag.

Address map (NUM_CH = 8): 0 = control, 1 = status, 2 = conversion-complete flags, 3 = invalid-result tags, NUM_CH + n = result of channel n.

Top module: `adc_ctrl_flags`

## Requirements
- R1: After reset, every register reads 0, and irq, soc, busy and adc_on are all 0.
- R2: Control register bits: 7 = power on, 6 = fast clear, 5 = halt in wait, 4 = trigger level mode (1) or edge mode (0), 3 = trigger active high (1) or active low (0), 2 = trigger enable, 1 = sequence interrupt enable. Bit 0 reads as the sequence-complete flag AND bit 1, and writes to bit 0 are ignored.
- R3: seq_done sets the sequence-complete flag while adc_on is 1. Writing 1 to status bit 7 (address 1) clears the flag. irq equals the flag AND the interrupt enable. Status bit 0 mirrors busy.
- R4: With fast clear at 0, a read of a result register clears that channel's flag only if the flag was set at the latest read of the flags register (address 2). Without such a read, the flag stays set.
- R5: With fast clear at 1, any read or write of a result register clears that channel's flag at once.
- R6: If a flag is cleared and set in the same cycle, the flag ends up set. The same holds for the sequence-complete flag.
- R7: conv_vld, while adc_on is 1, stores conv_data in the result register of conv_ch and sets that channel's flag. Bus writes never change result data.
- R8: When the power-on bit goes from 0 to 1, busy is high for exactly RECOV_CYC cycles. soc stays 0 while busy is high.
- R9: While wait_mode is 1 and halt-in-wait is 1, adc_on is 0 and conversion and sequence events are ignored. With halt-in-wait at 0, wait_mode has no effect.
- R10: Leaving wait mode with halt-in-wait at 1 reloads the recovery counter. The first conversion after that sets its channel's bit in the tags register. A later conversion on that channel clears the bit.
- R11: In edge mode, soc is a one-cycle pulse two cycles after an edge of the selected polarity on trig_in. The other edge, or a cleared trigger enable, gives no pulse.
- R12: In level mode, soc is 1 on every cycle in which the synchronised trigger is at its active level and seq_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| trig_in | input | 1 | Asynchronous external trigger |
| seq_busy | input | 1 | Sequencer is running a conversion |
| conv_vld | input | 1 | A conversion has finished |
| conv_ch | input | 3 | Channel of the finished conversion |
| conv_data | input | 8 | Result of the finished conversion |
| seq_done | input | 1 | The sequence has finished |
| wait_mode | input | 1 | System is in wait mode |
| irq | output | 1 | Sequence-complete interrupt request |
| soc | output | 1 | Start-of-conversion request |
| adc_on | output | 1 | Converter is powered and running |
| busy | output | 1 | Recovery delay is running |

## Verification
The bench aims at the access-order cases. These are a result read with no earlier flags read, a flags read taken before the flag was set, and a set that lands in the same cycle as a clearing access. A design that ignores the arming snapshot, or lets the clear win, shows the wrong flag byte. Random mixes of conversions and accesses, in both clear modes, are compared with a bench model.

Other directed cases cover the edge-detector timing and polarity, and the exact length of the recovery window. They also cover the invalid tag after a wait exit and events dropped during a halted wait. An off-by-one counter, a pulse two cycles long, or a tag that never clears each change a sampled output.

// File: rtl/adc_cf_pkg.sv
package adc_cf_pkg;
    localparam int BUS_W      = 8;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_FLAGS = 2;
    localparam int ADDR_TAGS  = 3;

    typedef struct packed {
        logic pwr_on;
        logic fast_clr;
        logic wait_off;
        logic trig_level;
        logic trig_high;
        logic trig_en;
        logic seq_ie;
        logic zero;
    } ctrl_t;
endpackage

// File: rtl/adc_trig_cond.sv
module adc_trig_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic level_mode,
    input  logic active_high,
    input  logic enable,
    input  logic ready,
    input  logic seq_busy,
    output logic soc
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  active, edge_hit;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = trig_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        active    = (st_q.s2 == active_high);
        edge_hit  = active && (st_q.prev != active_high);
        soc       = enable && ready && !seq_busy && (level_mode ? active : edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_pwr_recov.sv
module adc_pwr_recov #(
    parameter int RECOV_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic run,
    input  logic reload,
    output logic busy
);
    localparam int CNT_W = $clog2(RECOV_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)                    cnt_d = CNT_W'(RECOV_CYC);
        else if (!pwr_on)              cnt_d = '0;
        else if (run && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_clr,
    input  logic              conv_ok,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              tag_first,
    input  logic              flags_rd,
    input  logic              res_rd,
    input  logic              res_wr,
    input  logic [CH_W-1:0]   res_ch,
    output logic [NUM_CH-1:0] ccf,
    output logic [NUM_CH-1:0] tags,
    output logic [DATA_W-1:0] res_rdata
);
    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] res;
        logic [NUM_CH-1:0]             ccf;
        logic [NUM_CH-1:0]             armed;
        logic [NUM_CH-1:0]             tags;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (flags_rd) bk_d.armed = bk_q.ccf;
        if (fast_clr) begin
            if (res_rd || res_wr) bk_d.ccf[res_ch] = 1'b0;
        end else if (res_rd) begin
            if (bk_q.armed[res_ch]) bk_d.ccf[res_ch] = 1'b0;
            bk_d.armed[res_ch] = 1'b0;
        end
        // a set in the same cycle overrides any clear above
        if (conv_ok) begin
            bk_d.ccf[conv_ch]  = 1'b1;
            bk_d.res[conv_ch]  = conv_data;
            bk_d.tags[conv_ch] = tag_first;
        end
        ccf       = bk_q.ccf;
        tags      = bk_q.tags;
        res_rdata = bk_q.res[res_ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end
endmodule

// File: rtl/adc_ctrl_flags.sv
module adc_ctrl_flags
    import adc_cf_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int RECOV_CYC = 16,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int ADDR_W   = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              trig_in,
    input  logic              seq_busy,
    input  logic              conv_vld,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [BUS_W-1:0]  conv_data,
    input  logic              seq_done,
    input  logic              wait_mode,
    output logic              irq,
    output logic              soc,
    output logic              adc_on,
    output logic              busy
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  scf;
        logic  wait_prev;
        logic  pend_inv;
    } top_t;

    top_t st_d, st_q;

    logic              is_res, wr_ctrl, flags_rd, halted, conv_ok, reload, ready;
    logic [CH_W-1:0]   lo;
    logic [NUM_CH-1:0] ccf_vec, tag_vec;
    logic [BUS_W-1:0]  res_rdata, ctrl_raw;

    always_comb begin
        st_d     = st_q;
        is_res   = bus_addr[ADDR_W-1];
        lo       = bus_addr[CH_W-1:0];
        wr_ctrl  = bus_wr && !is_res && lo == CH_W'(ADDR_CTRL);
        flags_rd = bus_rd && !is_res && lo == CH_W'(ADDR_FLAGS);
        halted   = wait_mode && st_q.ctrl.wait_off;
        adc_on   = st_q.ctrl.pwr_on && !halted;
        conv_ok  = conv_vld && adc_on;
        reload   = (wr_ctrl && bus_wdata[BUS_W-1] && !st_q.ctrl.pwr_on)
                || (st_q.wait_prev && !wait_mode && st_q.ctrl.wait_off && st_q.ctrl.pwr_on);

        if (wr_ctrl) begin
            st_d.ctrl      = ctrl_t'(bus_wdata);
            st_d.ctrl.zero = 1'b0;
        end
        if (bus_wr && !is_res && lo == CH_W'(ADDR_STAT) && bus_wdata[BUS_W-1])
            st_d.scf = 1'b0;
        if (seq_done && adc_on)
            st_d.scf = 1'b1;
        st_d.wait_prev = wait_mode;
        if (reload && st_q.wait_prev) st_d.pend_inv = 1'b1;
        else if (conv_ok)             st_d.pend_inv = 1'b0;

        ctrl_raw = st_q.ctrl;
        irq      = st_q.ctrl.seq_ie && st_q.scf;
        ready    = adc_on && !busy;

        bus_rdata = '0;
        if (is_res) begin
            bus_rdata = res_rdata;
        end else begin
            case (lo)
                CH_W'(ADDR_CTRL):  bus_rdata = {ctrl_raw[BUS_W-1:1], irq};
                CH_W'(ADDR_STAT):  bus_rdata = {st_q.scf, {(BUS_W-2){1'b0}}, busy};
                CH_W'(ADDR_FLAGS): bus_rdata = BUS_W'(ccf_vec);
                CH_W'(ADDR_TAGS):  bus_rdata = BUS_W'(tag_vec);
                default:           bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    adc_pwr_recov #(.RECOV_CYC(RECOV_CYC)) recov_i (
        .clk(clk), .rst_n(rst_n), .pwr_on(st_q.ctrl.pwr_on),
        .run(!halted), .reload(reload), .busy(busy)
    );

    adc_trig_cond trig_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .level_mode(st_q.ctrl.trig_level), .active_high(st_q.ctrl.trig_high),
        .enable(st_q.ctrl.trig_en), .ready(ready), .seq_busy(seq_busy), .soc(soc)
    );

    adc_flag_bank #(.NUM_CH(NUM_CH), .DATA_W(BUS_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .fast_clr(st_q.ctrl.fast_clr),
        .conv_ok(conv_ok), .conv_ch(conv_ch), .conv_data(conv_data),
        .tag_first(st_q.pend_inv), .flags_rd(flags_rd),
        .res_rd(bus_rd && is_res), .res_wr(bus_wr && is_res), .res_ch(lo),
        .ccf(ccf_vec), .tags(tag_vec), .res_rdata(res_rdata)
    );
endmodule

// File: rtl/adc_ctrl_flags_chk.sv
module adc_ctrl_flags_chk #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        ctrl_raw,
    input logic [NUM_CH-1:0] ccf_vec,
    input logic              conv_vld,
    input logic [CH_W-1:0]   conv_ch,
    input logic              seq_done,
    input logic              wait_mode,
    input logic              seq_busy,
    input logic              bus_wr,
    input logic              irq,
    input logic              soc,
    input logic              adc_on,
    input logic              busy
);
    assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_raw[1] |-> !irq);

    assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && adc_on && ctrl_raw[1] && !bus_wr) |=> irq);

    assert_ccf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_vld && adc_on) |=> ccf_vec[$past(conv_ch)]);

    assert_soc_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soc |-> (!busy && adc_on));

    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && ctrl_raw[5]) |-> !adc_on);

    assert_edge_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && !ctrl_raw[4] && !bus_wr) |=> !soc);

    assert_idle_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !soc);
endmodule

bind adc_ctrl_flags adc_ctrl_flags_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_raw(ctrl_raw), .ccf_vec(ccf_vec),
    .conv_vld(conv_vld), .conv_ch(conv_ch), .seq_done(seq_done),
    .wait_mode(wait_mode), .seq_busy(seq_busy), .bus_wr(bus_wr),
    .irq(irq), .soc(soc), .adc_on(adc_on), .busy(busy)
);

// File: tb/adc_ctrl_flags_tb_top.sv
module adc_ctrl_flags_tb_top;
    localparam int NCH = 8;
    localparam int REC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       trig_in = 1'b0, seq_busy = 1'b0, conv_vld = 1'b0;
    logic [2:0] conv_ch = '0;
    logic [7:0] conv_data = '0;
    logic       seq_done = 1'b0, wait_mode = 1'b0;
    logic       irq, soc, adc_on, busy;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    adc_ctrl_flags #(.NUM_CH(NCH), .RECOV_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .seq_busy(seq_busy), .conv_vld(conv_vld),
        .conv_ch(conv_ch), .conv_data(conv_data), .seq_done(seq_done),
        .wait_mode(wait_mode), .irq(irq), .soc(soc), .adc_on(adc_on), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic conv(input int ch, input logic [7:0] d);
        @(negedge clk); conv_vld = 1'b1; conv_ch = ch[2:0]; conv_data = d;
        @(negedge clk); conv_vld = 1'b0;
    endtask

    function automatic logic [3:0] res_addr(input int ch);
        return 4'(NCH + ch);
    endfunction

    // expected clear outcome for one result access (bench model)
    function automatic logic clears(input logic fast, input logic is_rd, input logic armed);
        return fast ? 1'b1 : (is_rd && armed);
    endfunction

    task automatic rand_phase(input logic fast, input string tag);
        logic [7:0] ccf_m, arm_m, v, d;
        logic [7:0] res_m [NCH];
        int op, ch, ch2;
        wr(4'd0, 8'hC0);
        for (int c = 0; c < NCH; c++) begin
            rd(res_addr(c), v);
            res_m[c] = v;
        end
        wr(4'd0, fast ? 8'hC0 : 8'h80);
        rd(4'd2, v);
        check({tag, " flags start"}, v, 0);
        ccf_m = '0; arm_m = '0;
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            conv_vld = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
            op  = int'($urandom % 5);
            ch  = int'($urandom % NCH);
            ch2 = ($urandom % 2 == 0) ? ch : int'($urandom % NCH);
            d   = 8'($urandom);
            if (op == 0 || op == 3) begin conv_vld = 1'b1; conv_ch = ch[2:0]; conv_data = d; end
            if (op == 1) begin bus_addr = 4'd2; bus_rd = 1'b1; end
            if (op == 2 || op == 3) begin bus_addr = res_addr(ch2); bus_rd = 1'b1; end
            if (op == 4) begin bus_addr = res_addr(ch2); bus_wr = 1'b1; bus_wdata = 8'($urandom); end
            #1;
            if (op == 1) begin
                check({tag, " flags"}, bus_rdata, ccf_m);
                arm_m = ccf_m;
            end
            if (op >= 2) begin
                if (op != 4) check("R7 result data", bus_rdata, res_m[ch2]);
                if (clears(fast, op != 4, arm_m[ch2])) ccf_m[ch2] = 1'b0;
                if (!fast && op != 4) arm_m[ch2] = 1'b0;
            end
            if (op == 0 || op == 3) begin
                ccf_m[ch] = 1'b1;   // R6: set wins
                res_m[ch] = d;
            end
        end
        @(negedge clk); conv_vld = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        rd(4'd2, v);
        check({tag, " flags end"}, v, ccf_m);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt, idx, ssum;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 soc", soc, 0);
        check("R1 busy", busy, 0);
        check("R1 adc_on", adc_on, 0);
        rd(4'd0, v); check("R1 ctrl", v, 0);
        rd(4'd2, v); check("R1 flags", v, 0);
        rd(4'd1, v); check("R1 status", v, 0);

        // R2 / R3 control layout and interrupt flag
        wr(4'd0, 8'hC3);
        rd(4'd0, v); check("R2 bit0 ignores write", v, 8'hC2);
        @(negedge clk); seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
        check("R3 irq set", irq, 1);
        rd(4'd0, v); check("R2 bit0 mirrors flag", v, 8'hC3);
        rd(4'd1, v); check("R3 status flag", v[7], 1);
        wr(4'd0, 8'hC0);
        check("R2 irq gated off", irq, 0);
        rd(4'd0, v); check("R2 bit0 gated", v, 8'hC0);
        wr(4'd0, 8'hC2);
        check("R3 irq back", irq, 1);
        @(negedge clk); bus_addr = 4'd1; bus_wdata = 8'h80; bus_wr = 1'b1; seq_done = 1'b1;
        @(negedge clk); bus_wr = 1'b0; seq_done = 1'b0;
        check("R6 seq flag set wins", irq, 1);
        wr(4'd1, 8'h80);
        check("R3 w1c clears irq", irq, 0);

        // R5 fast clear
        conv(3, 8'h5A);
        rd(4'd2, v); check("R7 flag set", v[3], 1);
        wr(res_addr(3), 8'hFF);
        rd(4'd2, v); check("R5 write clears", v[3], 0);
        rd(res_addr(3), v); check("R7 write keeps data", v, 8'h5A);
        conv(4, 8'h11);
        rd(res_addr(4), v);
        rd(4'd2, v); check("R5 read clears", v[4], 0);

        // R4 normal order
        wr(4'd0, 8'h80);
        conv(4, 8'h22);
        rd(res_addr(4), v); check("R7 data", v, 8'h22);
        rd(4'd2, v); check("R4 no arm keeps flag", v[4], 1);
        rd(res_addr(4), v);
        rd(4'd2, v); check("R4 armed read clears", v[4], 0);
        conv(5, 8'h33);
        rd(res_addr(5), v);
        rd(4'd2, v); check("R4 stale arm keeps flag", v[5], 1);
        // R6 same-cycle set and clear
        @(negedge clk); bus_addr = res_addr(5); bus_rd = 1'b1;
        conv_vld = 1'b1; conv_ch = 3'd5; conv_data = 8'h44;
        @(negedge clk); bus_rd = 1'b0; conv_vld = 1'b0;
        rd(4'd2, v); check("R6 set wins", v[5], 1);

        // R8 recovery with level trigger waiting
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h1C);
        trig_in = 1'b1;
        wr(4'd0, 8'h9C);
        cnt = 0; ssum = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) cnt++;
            if (busy && soc) ssum++;
            @(negedge clk);
        end
        check("R8 busy length", cnt, REC);
        check("R8 no soc while busy", ssum, 0);
        // R12 level mode
        cnt = 0;
        for (int i = 0; i < 5; i++) begin if (soc) cnt++; @(negedge clk); end
        check("R12 level every cycle", cnt, 5);
        seq_busy = 1'b1; #1;
        check("R12 blocked when busy", soc, 0);
        seq_busy = 1'b0;

        // R11 edge mode, rising
        trig_in = 1'b0;
        wr(4'd0, 8'h8C);
        repeat (4) @(negedge clk);
        trig_in = 1'b1; cnt = 0; idx = 0;
        for (int i = 1; i <= 6; i++) begin @(negedge clk); if (soc) begin cnt++; idx = i; end end
        check("R11 one pulse", cnt, 1);
        check("R11 pulse timing", idx, 2);
        trig_in = 1'b0; cnt = 0;
        for (int i = 1; i <= 6; i++) begin @(negedge clk); if (soc) cnt++; end
        check("R11 wrong edge", cnt, 0);
        // falling polarity
        wr(4'd0, 8'h84);
        trig_in = 1'b1; repeat (4) @(negedge clk);
        trig_in = 1'b0; cnt = 0;
        for (int i = 1; i <= 6; i++) begin @(negedge clk); if (soc) cnt++; end
        check("R11 falling pulse", cnt, 1);
        // disabled
        wr(4'd0, 8'h88);
        trig_in = 1'b1; cnt = 0;
        for (int i = 1; i <= 6; i++) begin @(negedge clk); if (soc) cnt++; end
        check("R11 disabled", cnt, 0);
        trig_in = 1'b0;

        // R9 halt in wait
        wr(4'd0, 8'hC0);
        rd(res_addr(6), v);
        wr(4'd0, 8'hA0);
        @(negedge clk); wait_mode = 1'b1; #1;
        check("R9 halted", adc_on, 0);
        conv(6, 8'h66);
        @(negedge clk); seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
        rd(4'd2, v); check("R9 conv ignored", v[6], 0);
        rd(4'd1, v); check("R9 seq ignored", v[7], 0);
        // R10 exit reloads and tags
        @(negedge clk); wait_mode = 1'b0;
        @(negedge clk);
        check("R10 reload busy", busy, 1);
        repeat (REC + 2) @(negedge clk);
        check("R10 busy ends", busy, 0);
        conv(2, 8'h12);
        rd(4'd3, v); check("R10 first tagged", v[2], 1);
        conv(2, 8'h13);
        rd(4'd3, v); check("R10 tag cleared", v[2], 0);
        // R9 no halt when disabled
        wr(4'd0, 8'h80);
        @(negedge clk); wait_mode = 1'b1; #1;
        check("R9 runs in wait", adc_on, 1);
        conv(6, 8'h67);
        rd(4'd2, v); check("R9 conv kept", v[6], 1);
        @(negedge clk); wait_mode = 1'b0;
        @(negedge clk);
        check("R9 no reload", busy, 0);

        // random mixes
        rand_phase(1'b0, "R4");
        rand_phase(1'b1, "R5");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule